// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32768 Hz time-base enable into a programmable periodic interrupt. A free-running divider counts time-base ticks; a 4-bit rate code picks which divider stage marks the end of a period. Each period sets a periodic flag. The interrupt request follows that flag only while the periodic enable is set. The divider, and with it every periodic event, is held stopped while the 3-bit time-base field carries the all-ones "divider reset" value.

The rate table is not linear. Code 0 turns the output off. Codes 3 to 15 run from 8192 Hz down to 2 Hz, halving the rate at each step. Codes 1 and 2 repeat the rates of codes 8 and 9. The host reads the flag byte with a select and a read strobe. The read returns the state before the read, and it clears the flag and the request. A period that ends in the same cycle as the read wins, so the flag stays set. Software normally programs code 6, which gives 1024 Hz.

Top module: `periodic_irq_gen`

## Requirements
- R1: After a synchronous reset, `pflag`, `irq` and `rd_data` are all zero and the divider count is zero.
- R2: With rate code 0 the periodic flag is never set.
- R3: For rate code c in 3..15 the flag is set every 2^(c-1) ticks, so code 3 gives 4 ticks (8192 Hz) and code 15 gives 16384 ticks (2 Hz). The first event after the divider starts from zero comes after half a period.
- R4: Rate codes 1 and 2 give periods of 128 and 256 ticks, the same as codes 8 and 9.
- R5: Rate code 6 gives a period of 32 ticks (1024 Hz).
- R6: While `base_sel` equals 3'b111 the divider is held at zero and no periodic event occurs. After release, counting restarts from zero.
- R7: A periodic event sets `pflag`. On the same edge, `irq` is registered as the next flag value ANDed with `per_en`, so `irq` is low whenever `per_en` was low at the previous edge.
- R8: A read (`host_cs` and `host_rd` both high) clears `pflag` and `irq` at that edge. It also loads `rd_data` with bit 7 = flag AND enable and bit 6 = flag, taken before the clear, and all other bits zero. `rd_data` holds between reads.
- R9: A periodic event in the same cycle as a read keeps `pflag` set.
- R10: A change of rate code takes effect at the next rising edge of the newly selected divider stage. The change itself never produces an extra event.
- R11: The divider advances only on cycles with `tb_tick` high. Without ticks no event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_tick | input | 1 | One-cycle 32768 Hz time-base enable |
| base_sel | input | 3 | Time-base field; 3'b111 holds the divider in reset |
| rate_sel | input | 4 | Periodic rate code |
| per_en | input | 1 | Periodic interrupt enable |
| host_cs | input | 1 | Flag register select |
| host_rd | input | 1 | Read strobe |
| pflag | output | 1 | Periodic flag |
| irq | output | 1 | Interrupt request, active high |
| rd_data | output | 8 | Flag byte captured on the last read |

## Verification
The contested cycle is a host read that lands on the same edge as a period boundary. The flag must then survive, while the byte returned reflects the state before the read. The bench provokes this with a fixed read pattern that is coprime to the short periods, plus a directed read on a computed boundary tick. It judges each cycle against an arithmetic model of tick counts modulo the period. The same per-cycle comparison also covers rate changes in the middle of a period, where a stale divider stage must not produce an extra event.

// File: rtl/pir_pkg.sv
package pir_pkg;
  // all-ones time-base field holds the divider in reset
  localparam logic [2:0] BASE_HOLD = 3'b111;
  // flag byte layout decoded by the host side
  localparam int FLAG_BIT = 6;
  localparam int PEND_BIT = 7;
  // codes whose rates the two low non-zero codes repeat
  localparam int ALIAS_OF_1 = 8;
  localparam int ALIAS_OF_2 = 9;
endpackage

// File: rtl/pir_rate_decode.sv
module pir_rate_decode #(
  parameter int RATE_W = 4,
  parameter int DIV_W  = 15,
  parameter int TAP_W  = $clog2(DIV_W)
) (
  input  logic [RATE_W-1:0] code,
  output logic              tap_en,
  output logic [TAP_W-1:0]  tap_idx
);
  import pir_pkg::*;

  logic [TAP_W-1:0] raw_tap;

  // stage k rises once every 2^(k+1) ticks; code c wants 2^(c-1)
  always_comb begin
    unique case (code)
      RATE_W'(0): raw_tap = '0;
      RATE_W'(1): raw_tap = TAP_W'(ALIAS_OF_1 - 2);
      RATE_W'(2): raw_tap = TAP_W'(ALIAS_OF_2 - 2);
      default:    raw_tap = TAP_W'(code) - TAP_W'(2);
    endcase
  end

  assign tap_en  = (code != '0) && (int'(raw_tap) < DIV_W);
  assign tap_idx = raw_tap;
endmodule

// File: rtl/pir_divider.sv
module pir_divider #(
  parameter int DIV_W = 15,
  parameter int TAP_W = $clog2(DIV_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             tick,
  input  logic             tap_en,
  input  logic [TAP_W-1:0] tap_idx,
  output logic             period_evt
);
  localparam int TAP_N = 1 << TAP_W;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] low_ones;
  logic [TAP_N-1:0] rise_vec;

  always_ff @(posedge clk) begin
    if (rst || hold)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= cnt_q + 1'b1;
  end

  // a stage rises on the tick whose carry reaches it while it is low
  assign low_ones[0] = 1'b1;
  genvar gi;
  generate
    for (gi = 1; gi < DIV_W; gi++) begin : g_carry
      assign low_ones[gi] = low_ones[gi-1] & cnt_q[gi-1];
    end
    for (gi = 0; gi < TAP_N; gi++) begin : g_rise
      if (gi < DIV_W) begin : g_live
        assign rise_vec[gi] = low_ones[gi] & ~cnt_q[gi];
      end else begin : g_pad
        assign rise_vec[gi] = 1'b0;
      end
    end
  endgenerate

  assign period_evt = tick & ~hold & tap_en & rise_vec[tap_idx];
endmodule

// File: rtl/pir_flag.sv
module pir_flag #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt,
  input  logic              rd_stb,
  input  logic              irq_en,
  output logic              pflag,
  output logic              irq,
  output logic [DATA_W-1:0] rd_data
);
  import pir_pkg::*;

  logic              pf_q, irq_q, pf_nxt;
  logic [DATA_W-1:0] rd_q, rd_img;

  // a new period outranks the clearing read
  assign pf_nxt = evt ? 1'b1 : (rd_stb ? 1'b0 : pf_q);

  always_comb begin
    rd_img           = '0;
    rd_img[PEND_BIT] = pf_q & irq_en;
    rd_img[FLAG_BIT] = pf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_q  <= 1'b0;
      irq_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      pf_q  <= pf_nxt;
      irq_q <= pf_nxt & irq_en;
      if (rd_stb)
        rd_q <= rd_img;
    end
  end

  assign pflag   = pf_q;
  assign irq     = irq_q;
  assign rd_data = rd_q;
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen #(
  parameter int RATE_W = 4,
  parameter int BASE_W = 3,
  parameter int DIV_W  = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tb_tick,
  input  logic [BASE_W-1:0] base_sel,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              per_en,
  input  logic              host_cs,
  input  logic              host_rd,
  output logic              pflag,
  output logic              irq,
  output logic [DATA_W-1:0] rd_data
);
  import pir_pkg::*;

  localparam int TAP_W = $clog2(DIV_W);

  logic             tap_en, hold, evt, rd_stb;
  logic [TAP_W-1:0] tap_idx;

  assign hold   = (base_sel == BASE_W'(BASE_HOLD));
  assign rd_stb = host_cs & host_rd;

  pir_rate_decode #(.RATE_W(RATE_W), .DIV_W(DIV_W), .TAP_W(TAP_W)) u_dec (
    .code    (rate_sel),
    .tap_en  (tap_en),
    .tap_idx (tap_idx)
  );

  pir_divider #(.DIV_W(DIV_W), .TAP_W(TAP_W)) u_div (
    .clk        (clk),
    .rst        (rst),
    .hold       (hold),
    .tick       (tb_tick),
    .tap_en     (tap_en),
    .tap_idx    (tap_idx),
    .period_evt (evt)
  );

  pir_flag #(.DATA_W(DATA_W)) u_flag (
    .clk     (clk),
    .rst     (rst),
    .evt     (evt),
    .rd_stb  (rd_stb),
    .irq_en  (per_en),
    .pflag   (pflag),
    .irq     (irq),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/pir_chk.sv
module pir_chk #(
  parameter int RATE_W = 4,
  parameter int BASE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              tb_tick,
  input logic [BASE_W-1:0] base_sel,
  input logic [RATE_W-1:0] rate_sel,
  input logic              per_en,
  input logic              host_cs,
  input logic              host_rd,
  input logic              pflag,
  input logic              irq
);
  // R7
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> pflag);
  // R7
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !per_en |=> !irq);
  // R2
  code_zero_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == '0 && !pflag) |=> !pflag);
  // R6
  divider_hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (base_sel == '1 && !pflag) |=> !pflag);
  // R11
  no_tick_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!tb_tick && !pflag) |=> !pflag);
  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (host_cs && host_rd && !tb_tick) |=> (!pflag && !irq));
endmodule

bind periodic_irq_gen pir_chk #(.RATE_W(RATE_W), .BASE_W(BASE_W)) u_pir_chk (
  .clk      (clk),
  .rst      (rst),
  .tb_tick  (tb_tick),
  .base_sel (base_sel),
  .rate_sel (rate_sel),
  .per_en   (per_en),
  .host_cs  (host_cs),
  .host_rd  (host_rd),
  .pflag    (pflag),
  .irq      (irq)
);

// File: tb/tb_periodic_irq_gen.sv
`timescale 1ns/1ps
module tb_periodic_irq_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tb_tick = 1'b0;
  logic [2:0] base_sel = 3'b111;
  logic [3:0] rate_sel = 4'd0;
  logic       per_en = 1'b0;
  logic       host_cs = 1'b0;
  logic       host_rd = 1'b0;
  logic       pflag, irq;
  logic [7:0] rd_data;

  int    n_vec = 0;
  int    n_bad = 0;
  int    n_cnt = 0;
  logic  m_pf = 1'b0, m_irq = 1'b0;
  logic [7:0] m_rd = 8'h00;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  periodic_irq_gen dut (
    .clk(clk), .rst(rst), .tb_tick(tb_tick), .base_sel(base_sel),
    .rate_sel(rate_sel), .per_en(per_en), .host_cs(host_cs),
    .host_rd(host_rd), .pflag(pflag), .irq(irq), .rd_data(rd_data)
  );

  // period in ticks from the rate table; 0 means no output
  function automatic int period_of(input logic [3:0] c);
    if (c == 4'd0) return 0;
    if (c == 4'd1) return 128;
    if (c == 4'd2) return 256;
    return 1 << (int'(c) - 1);
  endfunction

  task automatic compare();
    n_vec++;
    if (pflag !== m_pf || irq !== m_irq || rd_data !== m_rd) begin
      n_bad++;
      $display("FAIL %s code=%0d pflag=%b irq=%b rd_data=%h expected pflag=%b irq=%b rd_data=%h",
               cur_req, rate_sel, pflag, irq, rd_data, m_pf, m_irq, m_rd);
    end
  endtask

  // one clock: drive, let the edge pass, update model, sample at negedge
  task automatic cyc(input logic t, input logic r);
    logic rd, ev;
    int   p;
    tb_tick = t; host_cs = r; host_rd = r;
    @(posedge clk);
    rd = r; ev = 1'b0;
    if (rst) begin
      n_cnt = 0; m_pf = 1'b0; m_irq = 1'b0; m_rd = 8'h00;
    end else begin
      if (rd) m_rd = {m_pf & per_en, m_pf, 6'b0};
      if (base_sel == 3'b111) n_cnt = 0;
      else if (t) begin
        n_cnt = (n_cnt + 1) % 32768;
        p = period_of(rate_sel);
        if (p != 0 && (n_cnt % p) == p / 2) ev = 1'b1;
      end
      m_pf  = ev ? 1'b1 : (rd ? 1'b0 : m_pf);
      m_irq = m_pf & per_en;
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    repeat (3) cyc(1'b1, 1'b0);
    rst = 1'b0;
    cyc(1'b0, 1'b0);

    // sweep of every rate code from a held divider
    per_en = 1'b1;
    for (int c = 0; c < 16; c++) begin
      int p, len;
      rate_sel = 4'(c);
      base_sel = 3'b111;
      cur_req = "R6";
      cyc(1'b1, 1'b1);
      cyc(1'b1, 1'b0);
      base_sel = 3'b010;
      p = period_of(4'(c));
      if (c == 0) cur_req = "R2";
      else if (c <= 2) cur_req = "R4";
      else if (c == 6) cur_req = "R5";
      else cur_req = "R3";
      len = (p == 0) ? 300 : 2 * p + 4;
      for (int k = 0; k < len; k++) cyc(1'b1, (k % 5) == 3);
    end

    // R9: read on the boundary tick of code 3 (event at 2nd tick)
    cur_req = "R9";
    rate_sel = 4'd3;
    base_sel = 3'b111; cyc(1'b1, 1'b1);
    base_sel = 3'b010;
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b1);
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);

    // R7: enable low keeps irq low while the flag runs
    cur_req = "R7";
    per_en = 1'b0; rate_sel = 4'd4;
    for (int k = 0; k < 60; k++) cyc(1'b1, (k % 7) == 6);
    per_en = 1'b1;
    for (int k = 0; k < 40; k++) cyc(1'b1, (k % 9) == 8);

    // R8: reads with no ticks clear and capture
    cur_req = "R8";
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);

    // R10: rate changes in mid period
    cur_req = "R10";
    rate_sel = 4'd9;
    for (int k = 0; k < 300; k++) cyc(1'b1, (k % 11) == 10);
    rate_sel = 4'd5;
    for (int k = 0; k < 70; k++) cyc(1'b1, (k % 11) == 10);
    rate_sel = 4'd9;
    for (int k = 0; k < 600; k++) cyc(1'b1, (k % 11) == 10);
    rate_sel = 4'd1;
    for (int k = 0; k < 300; k++) cyc(1'b1, (k % 11) == 10);

    // R11: sparse ticks, then none
    cur_req = "R11";
    rate_sel = 4'd3;
    for (int k = 0; k < 120; k++) cyc((k % 3) == 0, (k % 4) == 1);
    cyc(1'b0, 1'b1);
    for (int k = 0; k < 50; k++) cyc(1'b0, 1'b0);

    // R6: hold in mid run leaves flag but makes no new events
    cur_req = "R6";
    base_sel = 3'b111;
    for (int k = 0; k < 40; k++) cyc(1'b1, k == 20);
    base_sel = 3'b010;
    for (int k = 0; k < 20; k++) cyc(1'b1, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule